// File: doc/BRIEF.md
# Dual-Rail Word Codec with Completion Detection

The block carries an N-bit word across a dual-rail link. Each bit uses two wires: a one-rail and a zero-rail. On the transmit side, a registered encoder turns a single-rail word into rail pairs. When no word is offered, it drives every pair to the spacer, both wires low. Each word therefore reaches the link already separated from the next by a spacer.

On the receive side, the block samples the incoming rail pairs on every clock edge. A bit counts as present when either of its rails is high. The per-bit presence flags are reduced through a balanced tree. The result drives a single state element that behaves like a C-element:

- It sets once every bit is present.
- It clears once every bit has returned to the spacer.
- In any mixed condition it keeps its value.

When that state rises, the decoded word is captured from the one-rails. A pair with both rails high is not a legal code. It sets an error flag that stays set until reset.

The block is a clocked model of a self-timed link. Completion is inferred from the rails alone; no strobe travels with the data. Bits of a word may arrive on different cycles and in any order.

Top module: `drail_codec`

## Requirements
- R1: When `txValid` is high at a clock edge, then after that edge each bit i has `txOneRail[i]` equal to `txData[i]` and `txZeroRail[i]` equal to its inverse. The pair (one=1, zero=0) carries logic 1 and (one=0, zero=1) carries logic 0.
- R2: When `txValid` is low at a clock edge, both rail vectors are all zero after that edge, which is the spacer.
- R3: If `rxDone` is low and every receive pair has at least one rail high at a clock edge, `rxDone` is high after that edge.
- R4: If `rxDone` is high and every receive rail is low at a clock edge, `rxDone` is low after that edge.
- R5: In every other case `rxDone` keeps its value. Examples are a word that is only partly present, and a word that is partly withdrawn.
- R6: `rxData` loads the receive one-rails only at the edge where `rxDone` rises. At all other times it holds, even while the rails change under a high `rxDone`.
- R7: Completion does not depend on the order or the cycle in which individual bits arrive. `rxDone` rises only at the edge after the last missing bit appears.
- R8: A receive pair with both rails high sets `codeError` at the next edge, and it stays set until reset. Such a bit counts as present and decodes as 1.
- R9: Reset (active-low `rstN`) clears both transmit rail vectors, `rxDone`, `rxData` and `codeError` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txValid | input | 1 | Word offered to the encoder this cycle |
| txData | input | WIDTH | Single-rail word to encode |
| txOneRail | output | WIDTH | Encoded one-rails, one per bit |
| txZeroRail | output | WIDTH | Encoded zero-rails, one per bit |
| rxOneRail | input | WIDTH | Incoming one-rails |
| rxZeroRail | input | WIDTH | Incoming zero-rails |
| rxDone | output | 1 | Completion state of the receive word |
| rxData | output | WIDTH | Decoded single-rail word |
| codeError | output | 1 | Sticky flag for a both-rails-high pair |

## Verification
The encoder is driven with two complementary-heavy words and with idle cycles. This separates the one-rail and zero-rail mapping from the spacer insertion.

On the receiver, the tests cover three arrival patterns:
- A whole word arrives in one cycle, showing the basic rise.
- Bits trickle in one per cycle, showing that completion waits for the last bit.
- Bits are withdrawn one per cycle, showing the hold before the fall.

A second valid word is presented while completion is high, which separates capture-on-rise from continuous decoding. A word containing a both-high pair, followed by a spacer, shows that the error flag is sticky and that it is cleared only by reset.

// File: rtl/drail_pkg.sv
package drail_pkg;

  // strobes from the completion control to the datapath
  typedef struct packed {
    logic captureData;
    logic setDone;
    logic clearDone;
    logic flagError;
  } ctrlStrobe_t;

endpackage

// File: rtl/drail_ctree.sv
// Balanced reduction of per-bit presence into "all present" and "all spacer".
module drail_ctree #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] bitValid,
  output logic             allValid,
  output logic             allSpacer
);
  localparam int LEVELS = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam int LEAVES = 1 << LEVELS;

  for (genvar l = 0; l <= LEVELS; l++) begin : lvl
    localparam int NODES = LEAVES >> l;
    logic [NODES-1:0] fullV;
    logic [NODES-1:0] emptyV;
    if (l == 0) begin : leaf
      for (genvar i = 0; i < NODES; i++) begin : pad
        if (i < WIDTH) begin : real_bit
          assign fullV[i]  = bitValid[i];
          assign emptyV[i] = ~bitValid[i];
        end else begin : fill_bit
          assign fullV[i]  = 1'b1;
          assign emptyV[i] = 1'b1;
        end
      end
    end else begin : node
      for (genvar i = 0; i < NODES; i++) begin : join2
        assign fullV[i]  = lvl[l-1].fullV[2*i]  & lvl[l-1].fullV[2*i+1];
        assign emptyV[i] = lvl[l-1].emptyV[2*i] & lvl[l-1].emptyV[2*i+1];
      end
    end
  end

  assign allValid  = lvl[LEVELS].fullV[0];
  assign allSpacer = lvl[LEVELS].emptyV[0];

endmodule

// File: rtl/drail_datapath.sv
module drail_datapath
  import drail_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txValid,
  input  logic [WIDTH-1:0] txData,
  output logic [WIDTH-1:0] txOneRail,
  output logic [WIDTH-1:0] txZeroRail,
  input  logic [WIDTH-1:0] rxOneRail,
  input  logic [WIDTH-1:0] rxZeroRail,
  input  ctrlStrobe_t      strobe,
  output logic [WIDTH-1:0] rxData,
  output logic             allValid,
  output logic             allSpacer,
  output logic             anyIllegal
);
  logic [WIDTH-1:0] bitValid;
  logic [WIDTH-1:0] bitIllegal;

  // encoder: spacer whenever no word is offered
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txOneRail  <= '0;
      txZeroRail <= '0;
    end else if (txValid) begin
      txOneRail  <= txData;
      txZeroRail <= ~txData;
    end else begin
      txOneRail  <= '0;
      txZeroRail <= '0;
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : bitChk
    assign bitValid[i]   = rxOneRail[i] | rxZeroRail[i];
    assign bitIllegal[i] = rxOneRail[i] & rxZeroRail[i];
  end

  assign anyIllegal = |bitIllegal;

  drail_ctree #(.WIDTH(WIDTH)) uTree (
    .bitValid  (bitValid),
    .allValid  (allValid),
    .allSpacer (allSpacer)
  );

  // decoder register: loads only on the completion rise
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData <= '0;
    end else if (strobe.captureData) begin
      rxData <= rxOneRail;
    end
  end

endmodule

// File: rtl/drail_ctrl.sv
module drail_ctrl
  import drail_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        allValid,
  input  logic        allSpacer,
  input  logic        anyIllegal,
  output ctrlStrobe_t strobe,
  output logic        doneQ,
  output logic        errQ
);
  always_comb begin
    strobe.setDone     = allValid & ~doneQ;
    strobe.clearDone   = allSpacer & doneQ;
    strobe.captureData = strobe.setDone;
    strobe.flagError   = anyIllegal;
  end

  // C-element state: set on all-present, clear on all-spacer, else hold
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneQ <= 1'b0;
    end else if (strobe.setDone) begin
      doneQ <= 1'b1;
    end else if (strobe.clearDone) begin
      doneQ <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errQ <= 1'b0;
    end else if (strobe.flagError) begin
      errQ <= 1'b1;
    end
  end

endmodule

// File: rtl/drail_codec.sv
module drail_codec
  import drail_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txValid,
  input  logic [WIDTH-1:0] txData,
  output logic [WIDTH-1:0] txOneRail,
  output logic [WIDTH-1:0] txZeroRail,
  input  logic [WIDTH-1:0] rxOneRail,
  input  logic [WIDTH-1:0] rxZeroRail,
  output logic             rxDone,
  output logic [WIDTH-1:0] rxData,
  output logic             codeError
);
  ctrlStrobe_t strobe;
  logic        allValid;
  logic        allSpacer;
  logic        anyIllegal;

  drail_datapath #(.WIDTH(WIDTH)) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .txValid    (txValid),
    .txData     (txData),
    .txOneRail  (txOneRail),
    .txZeroRail (txZeroRail),
    .rxOneRail  (rxOneRail),
    .rxZeroRail (rxZeroRail),
    .strobe     (strobe),
    .rxData     (rxData),
    .allValid   (allValid),
    .allSpacer  (allSpacer),
    .anyIllegal (anyIllegal)
  );

  drail_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .allValid   (allValid),
    .allSpacer  (allSpacer),
    .anyIllegal (anyIllegal),
    .strobe     (strobe),
    .doneQ      (rxDone),
    .errQ       (codeError)
  );

endmodule

// File: rtl/drail_codec_chk.sv
module drail_codec_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             txValid,
  input logic [WIDTH-1:0] txData,
  input logic [WIDTH-1:0] txOneRail,
  input logic [WIDTH-1:0] txZeroRail,
  input logic [WIDTH-1:0] rxOneRail,
  input logic [WIDTH-1:0] rxZeroRail,
  input logic             rxDone,
  input logic [WIDTH-1:0] rxData,
  input logic             codeError
);
  AST_ENC_CODE: assert property (@(posedge clk) disable iff (!rstN)
    txValid |=> (txOneRail == $past(txData)) && (txZeroRail == ~$past(txData))); // R1

  AST_ENC_SPACER: assert property (@(posedge clk) disable iff (!rstN)
    !txValid |=> (txOneRail == '0) && (txZeroRail == '0)); // R2

  AST_DONE_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxDone) |-> $past(&(rxOneRail | rxZeroRail))); // R3

  AST_DONE_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxDone) |-> $past((rxOneRail | rxZeroRail) == '0)); // R4

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(&(rxOneRail | rxZeroRail)) && !$past((rxOneRail | rxZeroRail) == '0))
      |-> $stable(rxDone)); // R5

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(rxDone) |-> $stable(rxData)); // R6

  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rstN)
    $past(|(rxOneRail & rxZeroRail)) |-> codeError); // R8

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    $past(codeError) |-> codeError); // R8

endmodule

bind drail_codec drail_codec_chk #(.WIDTH(WIDTH)) uChk (.*);

// File: tb/drail_codec_test.sv
module drail_codec_test;
  localparam int W = 8;

  typedef struct {
    logic [W-1:0] txOne;
    logic [W-1:0] txZero;
    logic         done;
    logic [W-1:0] data;
    logic         err;
    string        req;
  } expItem_t;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         txValid = 1'b0;
  logic [W-1:0] txData = '0;
  logic [W-1:0] txOneRail, txZeroRail;
  logic [W-1:0] rxOneRail = '0;
  logic [W-1:0] rxZeroRail = '0;
  logic         rxDone;
  logic [W-1:0] rxData;
  logic         codeError;

  int tests = 0;
  int fails = 0;
  bit ended = 0;

  expItem_t     sb[$];
  logic         mDone = 0;
  logic [W-1:0] mData = '0;
  logic         mErr = 0;

  drail_codec #(.WIDTH(W)) uut (
    .clk(clk), .rstN(rstN), .txValid(txValid), .txData(txData),
    .txOneRail(txOneRail), .txZeroRail(txZeroRail),
    .rxOneRail(rxOneRail), .rxZeroRail(rxZeroRail),
    .rxDone(rxDone), .rxData(rxData), .codeError(codeError)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, expectation pushed to scoreboard
  task automatic step(input logic v, input logic [W-1:0] d,
                      input logic [W-1:0] one, input logic [W-1:0] zero,
                      input string req);
    expItem_t it;
    @(negedge clk);
    txValid = v; txData = d; rxOneRail = one; rxZeroRail = zero;
    it.txOne  = v ? d : '0;
    it.txZero = v ? ~d : '0;
    if (&(one | zero) && !mDone) begin
      mDone = 1'b1;
      mData = one;
    end else if (((one | zero) == '0) && mDone) begin
      mDone = 1'b0;
    end
    if (|(one & zero)) mErr = 1'b1;
    it.done = mDone; it.data = mData; it.err = mErr; it.req = req;
    sb.push_back(it);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; txValid = 0; txData = '0; rxOneRail = '0; rxZeroRail = '0;
    mDone = 0; mData = '0; mErr = 0;
    repeat (2) @(negedge clk);
    check("R9", "txOneRail", txOneRail, '0);
    check("R9", "txZeroRail", txZeroRail, '0);
    check("R9", "rxDone", {{(W-1){1'b0}}, rxDone}, '0);
    check("R9", "rxData", rxData, '0);
    check("R9", "codeError", {{(W-1){1'b0}}, codeError}, '0);
    rstN = 1'b1;
  endtask

  // monitor: compares outputs after each edge with the queued expectation
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        expItem_t e;
        e = sb.pop_front();
        check(e.req, "txOneRail", txOneRail, e.txOne);
        check(e.req, "txZeroRail", txZeroRail, e.txZero);
        check(e.req, "rxDone", {{(W-1){1'b0}}, rxDone}, {{(W-1){1'b0}}, e.done});
        check(e.req, "rxData", rxData, e.data);
        check(e.req, "codeError", {{(W-1){1'b0}}, codeError}, {{(W-1){1'b0}}, e.err});
      end
    end
  end

  initial begin
    #200000;
    if (!ended) begin
      ended = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] acc;
    doReset();

    // R1 and R2: encoder mapping and spacer insertion
    step(1, 8'hA5, '0, '0, "R1");
    step(0, 8'hFF, '0, '0, "R2");
    step(1, 8'h3C, '0, '0, "R1");
    step(0, 8'h00, '0, '0, "R2");

    // R3: full word in one cycle, R6: capture on rise
    step(0, '0, 8'h5A, ~8'h5A, "R3");
    // R6: a different valid word while done is high must not load
    step(0, '0, 8'hC3, ~8'hC3, "R6");
    // R5: partial withdrawal holds done high
    step(0, '0, 8'h03, 8'h00, "R5");
    // R4: spacer drops done
    step(0, '0, '0, '0, "R4");

    // R7: bits arrive one per cycle in a scattered order
    acc = '0;
    for (int k = 0; k < W; k++) begin
      int b;
      b = (k * 3) % W;
      acc[b] = 1'b1;
      step(0, '0, acc & 8'h96, acc & ~8'h96, "R7");
    end
    // R5: withdraw one bit per cycle, done holds until all gone
    for (int k = 0; k < W; k++) begin
      acc[k] = 1'b0;
      step(0, '0, acc & 8'h96, acc & ~8'h96, (k == W-1) ? "R4" : "R5");
    end

    // R8: illegal pair counts as present, decodes as 1, error sticks
    step(0, '0, 8'h11, 8'hEE | 8'h10, "R8");
    step(0, '0, '0, '0, "R8");
    step(1, 8'h0F, '0, '0, "R8");
    repeat (3) @(negedge clk);

    // R9: reset clears the sticky error
    doReset();
    step(0, '0, 8'hFF, 8'h00, "R3");
    repeat (3) @(negedge clk);

    if (!ended) begin
      ended = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule